// File: doc/BRIEF.md
# Reference-Compared Self-Test Sequencer

This block runs a self-test of a sequential unit under test against a trusted reference copy of the same circuit. A start pulse sends one reset cycle to both units through a single shared line. The block then applies one stimulus vector per cycle to both units at once and compares their outputs within that same cycle. Both units are assumed to produce outputs from their current state and the current input.

Vectors come from one of two sources. The first is an externally supplied sequence presented on an input port. The second is an internal 16-bit Galois LFSR that is seeded at start. A fault that acts only now and then can stay hidden for many vectors. For that reason the test declares a pass only after a programmed number of consecutive matching vectors. The first mismatch ends the test at once with a fail verdict and records the zero-based index of the vector that caused it.

Top module: `cmpseq_top`

## Requirements
- R1: A `start` pulse is accepted only while the block is idle or holding a verdict. A `start` pulse while `busy` is high has no effect, and `busy` is high exactly in the reset cycle and the run cycles.
- R2: In the cycle after an accepted start, `unitReset` is high for exactly one cycle and `vecValid` is low. `unitReset` is low in every other cycle.
- R3: With external mode selected (`cfgRandom`=0 at start), in every run cycle `testVector` equals `extVector`. Outside run cycles `testVector` is zero.
- R4: With random mode selected (`cfgRandom`=1 at start), the first run vector is the low VW bits of `cfgSeed`. A seed of zero is replaced by 16'hACE1. Each later vector is the next Galois step: shift right by one, then XOR 16'hB400 if the bit shifted out was 1.
- R5: A run cycle where `dutOut` differs from `refOut` sets `failFlag` in the next cycle and ends the run. `failIndex` then holds the zero-based count of vectors applied before the failing one.
- R6: If no mismatch occurs, `vecValid` is high for exactly `cfgLen` consecutive cycles. `passFlag` rises in the cycle after the last one.
- R7: A `cfgLen` of zero gives `passFlag` directly after the reset cycle, and no vector is applied.
- R8: A verdict (`passFlag` or `failFlag`, never both) and `failIndex` hold until the next accepted start. An accepted start clears both flags and sets `failIndex` to zero.
- R9: `cfgRandom`, `cfgLen` and `cfgSeed` are sampled only on an accepted start. Changing them during a run changes neither the vectors nor the length of the run.
- R10: After `rstN` is released, all flags, `unitReset`, `vecValid`, `testVector` and `failIndex` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset of the sequencer |
| start | input | 1 | Single-cycle request to begin a test |
| cfgRandom | input | 1 | Vector source: 1 LFSR, 0 external |
| cfgSeed | input | 16 | LFSR seed, taken at start |
| cfgLen | input | 16 | Number of consecutive matches required for a pass |
| extVector | input | VW (8) | Externally supplied vector for the current cycle |
| dutOut | input | OW (4) | Output of the unit under test |
| refOut | input | OW (4) | Output of the reference unit |
| unitReset | output | 1 | Shared reset to both units |
| testVector | output | VW (8) | Vector applied to both units |
| vecValid | output | 1 | A vector is applied and compared this cycle |
| busy | output | 1 | Reset or run in progress |
| passFlag | output | 1 | Pass verdict |
| failFlag | output | 1 | Fail verdict |
| failIndex | output | 16 | Index of the failing vector |

## Verification
The bench runs external-mode tests with fresh random vectors every cycle. These show that the output tracks the port and is not a stored or stale value. Random-mode tests, one with an explicit seed and one with a zero seed, tell the LFSR stepping and the seed substitution apart from a simple pass-through. Error injection at the first vector, at an interior vector and at the last vector separates correct index capture and early termination from off-by-one counting. Zero-length runs, a long run, and runs whose configuration inputs and start line are disturbed mid-run show that the programmed length and mode are latched at start and honoured.

// File: rtl/cmpseq_pkg.sv
`timescale 1ns/1ps
package cmpseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RESET = 3'd1,
    ST_RUN   = 3'd2,
    ST_PASS  = 3'd3,
    ST_FAIL  = 3'd4
  } seqState_t;

  typedef struct packed {
    logic loadCfg;      // latch configuration, seed LFSR, clear counters
    logic runActive;    // a vector is applied this cycle
    logic advance;      // matching vector: step counter and LFSR
    logic captureFail;  // mismatching vector: record its index
  } strobes_t;
endpackage

// File: rtl/cmpseq_ctrl.sv
`timescale 1ns/1ps
module cmpseq_ctrl
  import cmpseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     mismatch,
  input  logic     lenZero,
  input  logic     lastVec,
  output strobes_t stb,
  output logic     unitReset,
  output logic     busy,
  output logic     passFlag,
  output logic     failFlag
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext       = state;
    stb             = '0;
    case (state)
      ST_IDLE, ST_PASS, ST_FAIL: begin
        if (start) begin
          stateNext   = ST_RESET;
          stb.loadCfg = 1'b1;
        end
      end
      ST_RESET: stateNext = lenZero ? ST_PASS : ST_RUN;
      ST_RUN: begin
        stb.runActive = 1'b1;
        if (mismatch) begin
          stb.captureFail = 1'b1;
          stateNext       = ST_FAIL;
        end else begin
          stb.advance = 1'b1;
          if (lastVec) stateNext = ST_PASS;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign unitReset = (state == ST_RESET);
  assign busy      = (state == ST_RESET) || (state == ST_RUN);
  assign passFlag  = (state == ST_PASS);
  assign failFlag  = (state == ST_FAIL);

  // R5
  fail_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && mismatch) |=> (state == ST_FAIL));
  // R8
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_PASS || state == ST_FAIL) && !start) |=> $stable(state));
  // R2
  reset_before_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.runActive) |-> $past(state) == ST_RESET);
  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESET && lenZero) |=> (state == ST_PASS));
endmodule

// File: rtl/cmpseq_datapath.sv
`timescale 1ns/1ps
module cmpseq_datapath
  import cmpseq_pkg::*;
#(
  parameter int VW = 8,
  parameter int OW = 4,
  parameter int CW = 16,
  parameter int LW = 16,
  parameter logic [LW-1:0] TAP_MASK = 16'hB400,
  parameter logic [LW-1:0] SEED_FALLBACK = 16'hACE1
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      stb,
  input  logic          cfgRandom,
  input  logic [LW-1:0] cfgSeed,
  input  logic [CW-1:0] cfgLen,
  input  logic [VW-1:0] extVector,
  input  logic [OW-1:0] dutOut,
  input  logic [OW-1:0] refOut,
  output logic [VW-1:0] testVector,
  output logic          mismatch,
  output logic          lenZero,
  output logic          lastVec,
  output logic [CW-1:0] failIndex
);
  logic          modeReg;
  logic [CW-1:0] lenReg, vecCount, failReg;
  logic [LW-1:0] lfsrReg, lfsrNext;

  assign lfsrNext = {1'b0, lfsrReg[LW-1:1]} ^ (lfsrReg[0] ? TAP_MASK : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= 1'b0;
      lenReg   <= '0;
      vecCount <= '0;
      failReg  <= '0;
      lfsrReg  <= SEED_FALLBACK;
    end else if (stb.loadCfg) begin
      modeReg  <= cfgRandom;
      lenReg   <= cfgLen;
      vecCount <= '0;
      failReg  <= '0;
      lfsrReg  <= (cfgSeed == '0) ? SEED_FALLBACK : cfgSeed;
    end else begin
      if (stb.advance) begin
        vecCount <= vecCount + CW'(1);
        lfsrReg  <= lfsrNext;
      end
      if (stb.captureFail) failReg <= vecCount;
    end
  end

  assign testVector = stb.runActive ? (modeReg ? lfsrReg[VW-1:0] : extVector) : '0;
  assign mismatch   = stb.runActive && (dutOut != refOut);
  assign lenZero    = (lenReg == '0);
  assign lastVec    = (vecCount == lenReg - CW'(1));
  assign failIndex  = failReg;

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    lfsrReg != '0);
  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |-> vecCount < lenReg);
  // R8
  fail_index_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.loadCfg && !stb.captureFail) |=> $stable(failReg));
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadCfg |=> ($stable(lenReg) && $stable(modeReg)));
endmodule

// File: rtl/cmpseq_top.sv
`timescale 1ns/1ps
module cmpseq_top
  import cmpseq_pkg::*;
#(
  parameter int VW = 8,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          cfgRandom,
  input  logic [15:0]   cfgSeed,
  input  logic [15:0]   cfgLen,
  input  logic [VW-1:0] extVector,
  input  logic [OW-1:0] dutOut,
  input  logic [OW-1:0] refOut,
  output logic          unitReset,
  output logic [VW-1:0] testVector,
  output logic          vecValid,
  output logic          busy,
  output logic          passFlag,
  output logic          failFlag,
  output logic [15:0]   failIndex
);
  localparam int CW = 16;
  localparam int LW = 16;

  strobes_t stb;
  logic     mismatch, lenZero, lastVec;

  cmpseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mismatch(mismatch),
    .lenZero(lenZero), .lastVec(lastVec), .stb(stb),
    .unitReset(unitReset), .busy(busy), .passFlag(passFlag), .failFlag(failFlag)
  );

  cmpseq_datapath #(.VW(VW), .OW(OW), .CW(CW), .LW(LW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgRandom(cfgRandom),
    .cfgSeed(cfgSeed), .cfgLen(cfgLen), .extVector(extVector),
    .dutOut(dutOut), .refOut(refOut), .testVector(testVector),
    .mismatch(mismatch), .lenZero(lenZero), .lastVec(lastVec),
    .failIndex(failIndex)
  );

  assign vecValid = stb.runActive;
endmodule

// File: tb/cmpseq_top_bench.sv
`timescale 1ns/1ps
module cmpseq_top_bench;
  localparam int VW = 8;
  localparam int OW = 4;
  localparam int M_IDLE = 0, M_RST = 1, M_RUN = 2, M_PASS = 3, M_FAIL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic cfgRandom = 1'b0;
  logic [15:0] cfgSeed = '0;
  logic [15:0] cfgLen = '0;
  logic [VW-1:0] extVector = '0;
  logic injectErr = 1'b0;
  logic [OW-1:0] dutOut, refOut;
  logic unitReset, vecValid, busy, passFlag, failFlag;
  logic [VW-1:0] testVector;
  logic [15:0] failIndex;

  always #2 clk = ~clk;

  // Both units modelled as the same combinational response; the unit under test
  // flips its lowest output bit when the bench injects an error.
  assign refOut = testVector[3:0] ^ testVector[7:4];
  assign dutOut = refOut ^ {{(OW-1){1'b0}}, injectErr};

  cmpseq_top #(.VW(VW), .OW(OW)) u_cmpseq_top (
    .clk(clk), .rstN(rstN), .start(start), .cfgRandom(cfgRandom),
    .cfgSeed(cfgSeed), .cfgLen(cfgLen), .extVector(extVector),
    .dutOut(dutOut), .refOut(refOut), .unitReset(unitReset),
    .testVector(testVector), .vecValid(vecValid), .busy(busy),
    .passFlag(passFlag), .failFlag(failFlag), .failIndex(failIndex)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  // Behavioural reference state
  int mSt = M_IDLE;
  int mCnt = 0;
  int mLen = 0;
  int mFidx = 0;
  bit mMode = 0;
  logic [15:0] mLfsr = 16'hACE1;
  int injectAt = -1;
  bit scramble = 0;

  function automatic logic [15:0] galoisStep(input logic [15:0] v);
    if (v[0]) return (v >> 1) ^ 16'hB400;
    return v >> 1;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  task automatic doCycle(input bit st);
    bit held;
    bit inj;
    int expTv;
    @(negedge clk);
    cycles++;
    start = st;
    extVector = VW'($urandom);
    if (scramble && mSt == M_RUN) begin
      cfgRandom = ~cfgRandom;
      cfgLen = 16'($urandom);
      cfgSeed = 16'($urandom);
    end
    inj = (mSt == M_RUN) && (mCnt == injectAt);
    injectErr = inj;
    #1;
    held = (mSt == M_PASS || mSt == M_FAIL);
    expTv = (mSt == M_RUN) ? (mMode ? int'(mLfsr[VW-1:0]) : int'(extVector)) : 0;
    check("R2", "unitReset", unitReset, mSt == M_RST);
    check("R6", "vecValid", vecValid, mSt == M_RUN);
    check("R1", "busy", busy, mSt == M_RST || mSt == M_RUN);
    check(scramble ? "R9" : (mMode ? "R4" : "R3"), "testVector", testVector, expTv);
    check(held ? "R8" : (mLen == 0 ? "R7" : "R6"), "passFlag", passFlag, mSt == M_PASS);
    check(held ? "R8" : "R5", "failFlag", failFlag, mSt == M_FAIL);
    check("R5", "failIndex", failIndex, mFidx);
    // advance the reference model
    case (mSt)
      M_IDLE, M_PASS, M_FAIL: if (st) begin
        mSt = M_RST; mLen = cfgLen; mMode = cfgRandom;
        mLfsr = (cfgSeed == 0) ? 16'hACE1 : cfgSeed;
        mCnt = 0; mFidx = 0;
      end
      M_RST: mSt = (mLen == 0) ? M_PASS : M_RUN;
      M_RUN: begin
        if (inj) begin
          mSt = M_FAIL; mFidx = mCnt;
        end else begin
          if (mCnt == mLen - 1) mSt = M_PASS;
          mCnt++;
          mLfsr = galoisStep(mLfsr);
        end
      end
      default: mSt = M_IDLE;
    endcase
  endtask

  task automatic runTest(input bit mode, input int len, input logic [15:0] seed,
                         input int inj, input bit scr);
    int guard;
    cfgRandom = mode; cfgLen = 16'(len); cfgSeed = seed;
    injectAt = inj; scramble = 0;
    doCycle(1);
    scramble = scr;
    guard = 0;
    while ((mSt == M_RST || mSt == M_RUN) && guard < 70000) begin
      // R1: a start pulse during the run must be ignored
      doCycle(scr && mSt == M_RUN && mCnt == 2);
      guard++;
    end
    scramble = 0;
    for (int k = 0; k < 3; k++) doCycle(0);  // R8: verdict held
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10 reset state
    check("R10", "reset flags", {unitReset, vecValid, busy, passFlag, failFlag}, 0);
    check("R10", "reset testVector", testVector, 0);
    check("R10", "reset failIndex", failIndex, 0);
    doCycle(0);
    doCycle(0);
    runTest(1'b0, 5, 16'h0001, -1, 1'b0);     // R3, R6 external pass
    runTest(1'b0, 6, 16'h0001, 3, 1'b0);      // R5 interior failure
    runTest(1'b1, 20, 16'h1234, -1, 1'b1);    // R4, R9, R1 disturbed run
    runTest(1'b1, 9, 16'h0000, 0, 1'b0);      // R4 zero seed, R5 first vector
    runTest(1'b0, 0, 16'h0001, -1, 1'b0);     // R7 zero length
    runTest(1'b1, 8, 16'hBEEF, 7, 1'b0);      // R5 last vector fails
    runTest(1'b1, 300, 16'h8001, -1, 1'b0);   // R6 long run
    runTest(1'b0, 1, 16'h0001, -1, 1'b1);     // R6 single vector
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule